// File: doc/BRIEF.md
# Planar Adaptive Route Selector

This block computes the next hop for a packet at one router of a three-dimensional mesh. The mesh has no wraparound links. Routing is adaptive, but only inside one two-dimensional plane at a time. A packet first moves in the plane spanned by X and Y. Once its X coordinate matches the destination, it switches to the plane spanned by Y and Z. After that switch it never takes an X hop again.

Each cycle the router presents three things: the local coordinates, the destination coordinates from the head flit, and the one-bit plane tag carried in that flit. It also supplies a busy flag for every output port. Within the current plane the selector picks a free productive port, preferring the lower dimension. If no productive port is free, the request stalls and is retried. The selector computes the outgoing plane tag and a virtual channel class that equals the plane. It registers the decision and offers it to the switch allocator with a valid/ready handshake.

Top module: `par_route_sel`

## Requirements
- R1: After reset, `rt_valid_o` is 0 and stays 0 until a request is accepted.
- R2: Port codes are 0 local, 1 X+, 2 X-, 3 Y+, 4 Y-, 5 Z+, 6 Z-, and bit k of `busy_i` marks port k busy. The sign of destination minus current picks the + or - port of a dimension.
- R3: In plane 0 (tag in is 0 and X unresolved), the productive X port is chosen whenever it is free, even if the Y port is also free.
- R4: In plane 0 with the X port busy, the productive Y port is chosen if Y is unresolved and that port is free. Z is never chosen in plane 0.
- R5: The outgoing plane tag is 1 when the incoming tag is 1 or X is resolved, and 0 otherwise. With tag 1, no X port is ever chosen, even if X differs.
- R6: In plane 1, the productive Y port is preferred. The productive Z port is chosen when Y is resolved or its port is busy.
- R7: In plane 1 with Y and Z both resolved, the packet goes to port 0. It stalls if port 0 is busy.
- R8: When no allowed port is free, `req_ready_o` is 0 and no decision is issued that cycle.
- R9: The virtual channel class `rt_vc_o` equals the outgoing plane tag.
- R10: While `rt_valid_o` is 1 and `rt_ready_i` is 0, the decision stays stable and `req_ready_o` is 0. An accepted decision appears on the outputs one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Head flit present for routing |
| req_ready_o | output | 1 | Request accepted this cycle |
| cur_x_i | input | CW | Local X coordinate |
| cur_y_i | input | CW | Local Y coordinate |
| cur_z_i | input | CW | Local Z coordinate |
| dst_x_i | input | CW | Destination X coordinate |
| dst_y_i | input | CW | Destination Y coordinate |
| dst_z_i | input | CW | Destination Z coordinate |
| plane_i | input | 1 | Incoming plane tag |
| busy_i | input | 7 | Per-output-port busy flags |
| rt_valid_o | output | 1 | Registered decision valid |
| rt_ready_i | input | 1 | Switch allocator takes decision |
| rt_port_o | output | 3 | Chosen output port code |
| rt_vc_o | output | 1 | Virtual channel class |
| rt_plane_o | output | 1 | Outgoing plane tag |

## Verification
The bench aims at four kinds of trouble.

- **Plane 0 preference.** It busies the X port in plane 0. A selector that waits for X, or that falls through to Z, would stall or misroute where a Y hop was legal.
- **Stale plane tag.** It feeds a tag of 1 with X still differing. A design that trusts the coordinates over the tag would route back into X.
- **Ejection.** It covers matching coordinates with the local port free and with it busy. A wrong design would eject while the port is blocked, or never eject.
- **Backpressure.** It holds off the allocator. A broken register stage would drop or change a held decision, or accept a second one.

// File: rtl/par_route_pkg.sv
package par_route_pkg;
  localparam int NUM_PORTS = 7;
  localparam int NUM_DIMS  = 3;
  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_XP    = 3'd1,
    PORT_XN    = 3'd2,
    PORT_YP    = 3'd3,
    PORT_YN    = 3'd4,
    PORT_ZP    = 3'd5,
    PORT_ZN    = 3'd6
  } port_e;
endpackage

// File: rtl/par_dim_cmp.sv
module par_dim_cmp #(
  parameter int CW = 4
) (
  input  logic [CW-1:0] cur_i,
  input  logic [CW-1:0] dst_i,
  output logic          need_o,
  output logic          pos_o
);
  assign need_o = (cur_i != dst_i);
  assign pos_o  = (dst_i > cur_i);
endmodule

// File: rtl/par_plane_pick.sv
module par_plane_pick
  import par_route_pkg::*;
(
  input  logic [NUM_DIMS-1:0]  need_i,
  input  logic [NUM_DIMS-1:0]  pos_i,
  input  logic                 plane_i,
  input  logic [NUM_PORTS-1:0] busy_i,
  output logic                 found_o,
  output port_e                port_o,
  output logic                 plane_o
);
  port_e dim_port [NUM_DIMS];

  for (genvar d = 0; d < NUM_DIMS; d++) begin : g_dir
    assign dim_port[d] = port_e'(3'(2*d + 1 + (pos_i[d] ? 0 : 1)));
  end

  // plane 1 once X is resolved or tag already advanced
  assign plane_o = plane_i | ~need_i[0];

  logic  lo_ok, hi_ok;
  port_e lo_port, hi_port;
  logic  lo_need, hi_need;

  always_comb begin
    if (!plane_o) begin
      lo_need = need_i[0]; lo_port = dim_port[0];
      hi_need = need_i[1]; hi_port = dim_port[1];
    end else begin
      lo_need = need_i[1]; lo_port = dim_port[1];
      hi_need = need_i[2]; hi_port = dim_port[2];
    end
    lo_ok = lo_need && !busy_i[lo_port];
    hi_ok = hi_need && !busy_i[hi_port];
  end

  always_comb begin
    found_o = 1'b0;
    port_o  = PORT_LOCAL;
    if (lo_ok) begin
      found_o = 1'b1;
      port_o  = lo_port;
    end else if (hi_ok) begin
      found_o = 1'b1;
      port_o  = hi_port;
    end else if (plane_o && !lo_need && !hi_need && !busy_i[PORT_LOCAL]) begin
      found_o = 1'b1;
      port_o  = PORT_LOCAL;
    end
  end
endmodule

// File: rtl/par_route_reg.sv
module par_route_reg
  import par_route_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  port_e port_i,
  input  logic  plane_i,
  input  logic  ready_i,
  output logic  valid_o,
  output port_e port_o,
  output logic  plane_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      port_o  <= PORT_LOCAL;
      plane_o <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      port_o  <= port_i;
      plane_o <= plane_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/par_route_sel.sv
module par_route_sel
  import par_route_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [CW-1:0]        cur_x_i,
  input  logic [CW-1:0]        cur_y_i,
  input  logic [CW-1:0]        cur_z_i,
  input  logic [CW-1:0]        dst_x_i,
  input  logic [CW-1:0]        dst_y_i,
  input  logic [CW-1:0]        dst_z_i,
  input  logic                 plane_i,
  input  logic [NUM_PORTS-1:0] busy_i,
  output logic                 rt_valid_o,
  input  logic                 rt_ready_i,
  output logic [2:0]           rt_port_o,
  output logic                 rt_vc_o,
  output logic                 rt_plane_o
);
  logic [CW-1:0]       cur [NUM_DIMS];
  logic [CW-1:0]       dst [NUM_DIMS];
  logic [NUM_DIMS-1:0] need, pos;

  assign cur[0] = cur_x_i; assign dst[0] = dst_x_i;
  assign cur[1] = cur_y_i; assign dst[1] = dst_y_i;
  assign cur[2] = cur_z_i; assign dst[2] = dst_z_i;

  for (genvar d = 0; d < NUM_DIMS; d++) begin : g_dim
    par_dim_cmp #(.CW(CW)) i_cmp (
      .cur_i (cur[d]),
      .dst_i (dst[d]),
      .need_o(need[d]),
      .pos_o (pos[d])
    );
  end

  logic  found, nxt_plane;
  port_e nxt_port, reg_port;

  par_plane_pick i_pick (
    .need_i (need),
    .pos_i  (pos),
    .plane_i(plane_i),
    .busy_i (busy_i),
    .found_o(found),
    .port_o (nxt_port),
    .plane_o(nxt_plane)
  );

  assign req_ready_o = found && (!rt_valid_o || rt_ready_i);

  par_route_reg i_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (req_valid_i && req_ready_o),
    .port_i (nxt_port),
    .plane_i(nxt_plane),
    .ready_i(rt_ready_i),
    .valid_o(rt_valid_o),
    .port_o (reg_port),
    .plane_o(rt_plane_o)
  );

  assign rt_port_o = reg_port;
  assign rt_vc_o   = rt_plane_o;
endmodule

// File: rtl/par_route_sel_chk.sv
module par_route_sel_chk #(
  parameter int CW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic [CW-1:0] cur_x_i,
  input logic [CW-1:0] cur_y_i,
  input logic [CW-1:0] cur_z_i,
  input logic [CW-1:0] dst_x_i,
  input logic [CW-1:0] dst_y_i,
  input logic [CW-1:0] dst_z_i,
  input logic          plane_i,
  input logic [6:0]    busy_i,
  input logic          rt_valid_o,
  input logic          rt_ready_i,
  input logic [2:0]    rt_port_o,
  input logic          rt_vc_o,
  input logic          rt_plane_o
);
  logic acc;
  assign acc = req_valid_i && req_ready_o;

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_valid_o && !rt_ready_i |=> rt_valid_o && $stable(rt_port_o) && $stable(rt_plane_o)); // R10
  AST_NO_ACCEPT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_valid_o && !rt_ready_i |-> !req_ready_o); // R10
  AST_FREE_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> rt_valid_o && (($past(busy_i) & (7'b1 << rt_port_o)) == 7'b0)); // R8
  AST_NO_X_AFTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && plane_i |=> rt_port_o != 3'd1 && rt_port_o != 3'd2 && rt_plane_o); // R5
  AST_EJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && cur_x_i == dst_x_i && cur_y_i == dst_y_i && cur_z_i == dst_z_i |=> rt_port_o == 3'd0); // R7
  AST_PLANE0_PORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_valid_o && !rt_plane_o |-> rt_port_o >= 3'd1 && rt_port_o <= 3'd4); // R4
  AST_VC_PLANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_valid_o |-> rt_vc_o == rt_plane_o); // R9
endmodule

bind par_route_sel par_route_sel_chk #(.CW(CW)) i_par_route_sel_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .cur_x_i(cur_x_i), .cur_y_i(cur_y_i), .cur_z_i(cur_z_i),
  .dst_x_i(dst_x_i), .dst_y_i(dst_y_i), .dst_z_i(dst_z_i),
  .plane_i(plane_i), .busy_i(busy_i), .rt_valid_o(rt_valid_o), .rt_ready_i(rt_ready_i),
  .rt_port_o(rt_port_o), .rt_vc_o(rt_vc_o), .rt_plane_o(rt_plane_o)
);

// File: tb/test_par_route_sel.sv
module test_par_route_sel;
  localparam int CW = 3;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, plane = 0, rt_valid, rt_ready = 1, rt_vc, rt_plane;
  logic [CW-1:0] cx = 0, cy = 0, cz = 0, dx = 0, dy = 0, dz = 0;
  logic [6:0] busy = 0;
  logic [2:0] rt_port;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  par_route_sel #(.CW(CW)) i_par_route_sel (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .cur_x_i(cx), .cur_y_i(cy), .cur_z_i(cz), .dst_x_i(dx), .dst_y_i(dy), .dst_z_i(dz),
    .plane_i(plane), .busy_i(busy), .rt_valid_o(rt_valid), .rt_ready_i(rt_ready),
    .rt_port_o(rt_port), .rt_vc_o(rt_vc), .rt_plane_o(rt_plane)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // returns {stall, plane_out, port[2:0]}
  function automatic logic [4:0] model(input logic [CW-1:0] ax, ay, az, bx, by, bz,
                                       input logic pl, input logic [6:0] bs);
    logic p1 = pl | (ax == bx);
    logic [2:0] xp = (bx > ax) ? 3'd1 : 3'd2;
    logic [2:0] yp = (by > ay) ? 3'd3 : 3'd4;
    logic [2:0] zp = (bz > az) ? 3'd5 : 3'd6;
    if (!p1) begin
      if (!bs[xp]) return {1'b0, 1'b0, xp};
      if (ay != by && !bs[yp]) return {1'b0, 1'b0, yp};
      return {1'b1, 1'b0, 3'd0};
    end
    if (ay != by && !bs[yp]) return {1'b0, 1'b1, yp};
    if (az != bz && !bs[zp]) return {1'b0, 1'b1, zp};
    if (ay == by && az == bz && !bs[0]) return {1'b0, 1'b1, 3'd0};
    return {1'b1, 1'b1, 3'd0};
  endfunction

  task automatic route(input string req, input logic [CW-1:0] ax, ay, az, bx, by, bz,
                       input logic pl, input logic [6:0] bs);
    logic [4:0] e = model(ax, ay, az, bx, by, bz, pl, bs);
    @(negedge clk);
    cx = ax; cy = ay; cz = az; dx = bx; dy = by; dz = bz; plane = pl; busy = bs;
    req_valid = 1; rt_ready = 1;
    #1 check({req, " R8 ready"}, req_ready, !e[4]);
    @(negedge clk);
    req_valid = 0;
    check({req, " valid"}, rt_valid, !e[4]);
    if (!e[4]) begin
      check({req, " port"}, rt_port, e[2:0]);
      check({req, " R5 plane"}, rt_plane, e[3]);
      check({req, " R9 vc"}, rt_vc, e[3]);
    end
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD*2);
    #1 check("R1 reset valid", rt_valid, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); check("R1 idle valid", rt_valid, 0);

    route("R3 X preferred, R2 X+", 1,1,1, 5,4,2, 0, 7'b0);
    route("R2 X-", 5,1,1, 2,4,2, 0, 7'b0);
    route("R4 X busy use Y-", 3,5,1, 6,2,2, 0, 7'b0000010);
    route("R4 no Z in plane0", 3,5,1, 6,5,2, 0, 7'b0000010);
    route("R8 both busy stall", 3,5,1, 6,2,2, 0, 7'b0010010);
    route("R5 tag1 ignores X", 1,1,1, 5,4,2, 1, 7'b0);
    route("R5 X resolved advances", 4,1,1, 4,1,6, 0, 7'b0);
    route("R6 Y preferred", 4,1,1, 4,3,0, 0, 7'b0);
    route("R6 Y busy use Z-", 4,1,3, 4,3,0, 0, 7'b0001000);
    route("R7 eject", 2,2,2, 2,2,2, 0, 7'b1111110);
    route("R7 eject busy stall", 2,2,2, 2,2,2, 0, 7'b0000001);
    route("R7 tag1 X differs ejects", 1,2,2, 6,2,2, 1, 7'b0);

    // R10 backpressure
    @(negedge clk);
    cx = 0; cy = 0; cz = 0; dx = 3; dy = 3; dz = 3; plane = 0; busy = 0;
    req_valid = 1; rt_ready = 0;
    @(negedge clk);
    cx = 3; dz = 0; plane = 1;
    check("R10 held valid", rt_valid, 1);
    check("R10 held port", rt_port, 1);
    #1 check("R10 no accept", req_ready, 0);
    repeat (3) @(negedge clk);
    check("R10 still port", rt_port, 1);
    check("R10 still plane", rt_plane, 0);
    req_valid = 0; rt_ready = 1;
    @(negedge clk);
    check("R10 drained", rt_valid, 0);

    for (int i = 0; i < 400; i++) begin
      logic [CW-1:0] r[6];
      for (int k = 0; k < 6; k++) r[k] = CW'($urandom_range(0, (1 << CW) - 1));
      if ($urandom_range(0, 3) == 0) r[3] = r[0];
      if ($urandom_range(0, 3) == 0) r[4] = r[1];
      route("R2 random", r[0], r[1], r[2], r[3], r[4], r[5],
            ($urandom_range(0, 3) == 0), 7'($urandom) & 7'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule